// File: doc/BRIEF.md
# Pin Short-Circuit Readback Monitor

This block watches a group of output pins for shorts to ground or to the supply while they carry normal traffic. Each pin is driven as an output, and its input buffer stays enabled. The block passes the core's drive value and output enable straight through to the pad. It samples the pad level through a two-stage synchronizer and compares that sample against the value the core drove in the same cycle. A pin that was driven high but reads low is a short to ground. A pin that was driven low but reads high is a short to the supply. Because the pad path is never slowed or gated, the data rate of the pins is unaffected.

A settling setting selects a one-cycle window (slow clocks) or a two-cycle window (fast clocks). With the two-cycle window, a compare is made only when the drive value and the enable held steady for the current and the previous cycle. Any cycle with the output enable off is never compared. A mismatch must repeat on a programmable number of consecutive compares before a fault is declared. Faults are stored as sticky per-pin flags, cleared by write-one-to-clear, and summarised on one maskable interrupt line. An optional mode releases the driver of a faulted pin.

Top module: `pin_short_mon`

## Requirements
- R1: After reset, all ground-fault and supply-fault flags are 0 and fault_irq is 0.
- R2: pad_out equals drv_val in the same cycle, and pad_oe equals drv_oe for every pin that is not auto-disabled.
- R3: A pin driven high (drv_val bit 1, output enabled) whose pad reads 0 sets its bit in flt_gnd.
- R4: A pin driven low (drv_val bit 0, output enabled) whose pad reads 1 sets its bit in flt_vdd.
- R5: When a short appears in cycle j on a pin with a steady drive, its flag is first seen set after the (T+2)-th rising edge following the start of cycle j, where T is the threshold.
- R6: With cfg_settle2=0 every enabled cycle is compared. With cfg_settle2=1 a cycle is compared only when the drive value and the enable equal those of the previous cycle, so a pad that lags the drive by one cycle raises a fault at setting 0 but not at setting 1.
- R7: No fault is recorded from a cycle in which pad_oe of that pin was 0, whatever the pad level.
- R8: A fault needs cfg_thresh consecutive mismatching compares, and a matching compare restarts the count. cfg_thresh=0 acts as 1.
- R9: Flags hold until clr_wr is 1 at a clock edge with the pin's bit set in clr_bits. This clears both flags of only the selected pins. If a fault is declared on the same edge, the set wins.
- R10: fault_irq is 1 exactly when some pin has a flag set and its irq_mask bit is 0. A mask bit of 1 hides that pin.
- R11: With cfg_autodis=1, pad_oe of a pin falls on the edge that sets its flag. It stays low until that pin is cleared. With cfg_autodis=0, pad_oe is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_val | input | N_PINS | Value the core drives on each pin |
| drv_oe | input | N_PINS | Output enable requested by the core |
| pad_in | input | N_PINS | Level read back from each pad's input buffer |
| cfg_settle2 | input | 1 | 0: one-cycle settling window, 1: two-cycle window |
| cfg_thresh | input | 4 | Consecutive mismatches needed for a fault (0 acts as 1) |
| cfg_autodis | input | 1 | Release the driver of a faulted pin |
| irq_mask | input | N_PINS | 1 hides a pin from fault_irq |
| clr_wr | input | 1 | Clear strobe |
| clr_bits | input | N_PINS | Pins whose flags are cleared on clr_wr |
| pad_out | output | N_PINS | Value to the pad driver |
| pad_oe | output | N_PINS | Enable to the pad driver |
| flt_gnd | output | N_PINS | Sticky short-to-ground flags |
| flt_vdd | output | N_PINS | Sticky short-to-supply flags |
| fault_irq | output | 1 | Summary interrupt |

## Verification
A drive pipeline that is misaligned with the synchronizer shows up on the flag ports. A correct pin would then be flagged one cycle after its drive toggles, or a real short would be flagged a cycle early or late. Both are visible within T+3 edges. A mismatch counter that fails to restart on a matching compare raises a flag on intermittent shorts whose runs are shorter than the threshold. A compare made while the pin is tri-stated raises a flag on a pulled pad within three edges. An auto-disable bit that is stuck or never cleared shows as pad_oe differing from drv_oe.

// File: rtl/pin_mon_pkg.sv
package pin_mon_pkg;
    localparam int THR_W = 4;
    typedef logic [THR_W-1:0] thr_t;

    function automatic thr_t norm_thr(input thr_t raw);
        return (raw == '0) ? thr_t'(1) : raw;
    endfunction
endpackage

// File: rtl/pin_rb_sync.sv
module pin_rb_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/pin_lane.sv
module pin_lane
    import pin_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_val,
    input  logic oe_eff,
    input  logic rb_sync,
    input  logic settle2,
    input  thr_t thr,
    input  logic autodis,
    input  logic clr,
    output logic gnd_flag,
    output logic vdd_flag,
    output logic dis_flag
);
    localparam int DEPTH = SYNC_STAGES + 1;
    localparam int ALIGN = SYNC_STAGES - 1;

    typedef struct packed {
        logic [DEPTH-1:0] val;
        logic [DEPTH-1:0] oe;
        thr_t             cnt;
        logic             gnd;
        logic             vdd;
        logic             dis;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic           steady;
    logic           cmp_en;
    logic           miss;
    logic           declare;
    logic [THR_W:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        st_d.val = {st_q.val[DEPTH-2:0], drv_val};
        st_d.oe  = {st_q.oe[DEPTH-2:0], oe_eff};

        steady   = !settle2 ||
                   (st_q.oe[ALIGN+1] && (st_q.val[ALIGN+1] == st_q.val[ALIGN]));
        cmp_en   = st_q.oe[ALIGN] && steady;
        miss     = cmp_en && (st_q.val[ALIGN] != rb_sync);
        cnt_next = {1'b0, st_q.cnt} + {{THR_W{1'b0}}, 1'b1};
        declare  = miss && (cnt_next >= {1'b0, thr});

        if (cmp_en) begin
            if (!miss || declare) st_d.cnt = '0;
            else                  st_d.cnt = cnt_next[THR_W-1:0];
        end

        if (clr) begin
            st_d.gnd = 1'b0;
            st_d.vdd = 1'b0;
            st_d.dis = 1'b0;
        end

        if (declare) begin
            if (st_q.val[ALIGN]) st_d.gnd = 1'b1;
            else                 st_d.vdd = 1'b1;
            if (autodis)         st_d.dis = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnd_flag = st_q.gnd;
    assign vdd_flag = st_q.vdd;
    assign dis_flag = st_q.dis;
endmodule

// File: rtl/pin_short_mon.sv
module pin_short_mon
    import pin_mon_pkg::*;
#(
    parameter int N_PINS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] drv_val,
    input  logic [N_PINS-1:0] drv_oe,
    input  logic [N_PINS-1:0] pad_in,
    input  logic              cfg_settle2,
    input  logic [THR_W-1:0]  cfg_thresh,
    input  logic              cfg_autodis,
    input  logic [N_PINS-1:0] irq_mask,
    input  logic              clr_wr,
    input  logic [N_PINS-1:0] clr_bits,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] flt_gnd,
    output logic [N_PINS-1:0] flt_vdd,
    output logic              fault_irq
);
    logic [N_PINS-1:0] rb_sync;
    logic [N_PINS-1:0] dis_vec;
    thr_t              thr_eff;

    assign thr_eff = norm_thr(cfg_thresh);
    assign pad_out = drv_val;
    assign pad_oe  = drv_oe & ~dis_vec;

    pin_rb_sync #(
        .WIDTH  (N_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (rb_sync)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_lane
        pin_lane #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .drv_val  (drv_val[p]),
            .oe_eff   (pad_oe[p]),
            .rb_sync  (rb_sync[p]),
            .settle2  (cfg_settle2),
            .thr      (thr_eff),
            .autodis  (cfg_autodis),
            .clr      (clr_wr && clr_bits[p]),
            .gnd_flag (flt_gnd[p]),
            .vdd_flag (flt_vdd[p]),
            .dis_flag (dis_vec[p])
        );
    end

    assign fault_irq = |((flt_gnd | flt_vdd) & ~irq_mask);
endmodule

// File: rtl/pin_short_mon_chk.sv
module pin_short_mon_chk #(
    parameter int N_PINS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] drv_oe,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] flt_gnd,
    input logic [N_PINS-1:0] flt_vdd,
    input logic [N_PINS-1:0] irq_mask,
    input logic              clr_wr,
    input logic              fault_irq
);
    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (((flt_gnd | flt_vdd) & $past(flt_gnd | flt_vdd)) == $past(flt_gnd | flt_vdd)));

    // R7
    tri_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((flt_gnd | flt_vdd) & ~$past(flt_gnd | flt_vdd) & ~$past(pad_oe, 3)) == '0));

    // R11
    dis_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_oe & ~pad_oe & ~(flt_gnd | flt_vdd)) == '0));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&irq_mask) |-> !fault_irq);
endmodule

bind pin_short_mon pin_short_mon_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_oe    (drv_oe),
    .pad_oe    (pad_oe),
    .flt_gnd   (flt_gnd),
    .flt_vdd   (flt_vdd),
    .irq_mask  (irq_mask),
    .clr_wr    (clr_wr),
    .fault_irq (fault_irq)
);

// File: tb/pin_short_mon_bench.sv
module pin_short_mon_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] drv_val = '0, drv_oe = '0, pad_in;
    logic         cfg_settle2 = 1'b0;
    logic [3:0]   cfg_thresh = 4'd1;
    logic         cfg_autodis = 1'b0;
    logic [N-1:0] irq_mask = '0;
    logic         clr_wr = 1'b0;
    logic [N-1:0] clr_bits = '0;
    logic [N-1:0] pad_out, pad_oe, flt_gnd, flt_vdd;
    logic         fault_irq;

    logic [N-1:0] sh_g = '0, sh_v = '0, lag_en = '0, lag_q = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) lag_q <= pad_out;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (sh_g[i])        pad_in[i] = 1'b0;
            else if (sh_v[i])   pad_in[i] = 1'b1;
            else if (pad_oe[i]) pad_in[i] = lag_en[i] ? lag_q[i] : pad_out[i];
            else                pad_in[i] = ~pad_out[i];
        end
    end

    pin_short_mon #(.N_PINS(N)) u_pin_short_mon (
        .clk(clk), .rst_n(rst_n), .drv_val(drv_val), .drv_oe(drv_oe),
        .pad_in(pad_in), .cfg_settle2(cfg_settle2), .cfg_thresh(cfg_thresh),
        .cfg_autodis(cfg_autodis), .irq_mask(irq_mask), .clr_wr(clr_wr),
        .clr_bits(clr_bits), .pad_out(pad_out), .pad_oe(pad_oe),
        .flt_gnd(flt_gnd), .flt_vdd(flt_vdd), .fault_irq(fault_irq)
    );

    typedef struct packed {
        logic s2; logic [3:0] thr; logic ad;
        logic [3:0] oe; logic [3:0] val; logic [3:0] sg; logic [3:0] sv;
        logic [3:0] eg; logic [3:0] ev; logic [3:0] eoe; logic eirq;
    } vec_t;

    // fields: settle2, thresh, autodis, oe, val, short_gnd, short_vdd, exp gnd, exp vdd, exp pad_oe, exp irq
    localparam vec_t VECS [8] = '{
        '{1'b0, 4'd1,  1'b0, 4'hF, 4'hF, 4'h1, 4'h0, 4'h1, 4'h0, 4'hF, 1'b1}, // R3
        '{1'b0, 4'd3,  1'b0, 4'hF, 4'h0, 4'h0, 4'h2, 4'h0, 4'h2, 4'hF, 1'b1}, // R4
        '{1'b1, 4'd15, 1'b0, 4'hF, 4'hA, 4'h2, 4'h5, 4'h2, 4'h5, 4'hF, 1'b1}, // R3 R4 R6
        '{1'b0, 4'd1,  1'b0, 4'h0, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R7
        '{1'b1, 4'd2,  1'b0, 4'hF, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'hF, 1'b0}, // R3 no mismatch
        '{1'b0, 4'd2,  1'b1, 4'hF, 4'hF, 4'h4, 4'h0, 4'h4, 4'h0, 4'hB, 1'b1}, // R11
        '{1'b0, 4'd0,  1'b0, 4'hF, 4'h0, 4'h0, 4'h8, 4'h0, 4'h8, 4'hF, 1'b1}, // R8 thresh 0
        '{1'b1, 4'd1,  1'b0, 4'h3, 4'hF, 4'hC, 4'h0, 4'h0, 4'h0, 4'h3, 1'b0}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear(input logic [N-1:0] bits);
        clr_wr = 1'b1; clr_bits = bits;
        step(1);
        clr_wr = 1'b0; clr_bits = '0;
    endtask

    task automatic flush();
        sh_g = '0; sh_v = '0; lag_en = '0;
        drv_oe = '1; drv_val = '0; cfg_settle2 = 1'b0; cfg_thresh = 4'd1;
        cfg_autodis = 1'b0; irq_mask = '0;
        step(6);
        clear('1);
        step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        drv_val = 4'h5; drv_oe = 4'h6;
        step(2);
        check("R1 flt_gnd", flt_gnd, 0);
        check("R1 flt_vdd", flt_vdd, 0);
        check("R1 irq", fault_irq, 0);
        check("R2 pad_out", pad_out, 4'h5);
        check("R2 pad_oe", pad_oe, 4'h6);

        for (int v = 0; v < 8; v++) begin
            flush();
            cfg_settle2 = VECS[v].s2; cfg_thresh = VECS[v].thr; cfg_autodis = VECS[v].ad;
            drv_oe = VECS[v].oe; drv_val = VECS[v].val;
            sh_g = VECS[v].sg; sh_v = VECS[v].sv;
            step(24);
            check($sformatf("R3 vec%0d gnd", v), flt_gnd, VECS[v].eg);
            check($sformatf("R4 vec%0d vdd", v), flt_vdd, VECS[v].ev);
            check($sformatf("R11 vec%0d pad_oe", v), pad_oe, VECS[v].eoe);
            check($sformatf("R10 vec%0d irq", v), fault_irq, VECS[v].eirq);
        end

        // R5 latency, both settle settings
        for (int s = 0; s < 2; s++) begin
            flush();
            cfg_settle2 = s[0]; cfg_thresh = 4'd4; drv_val = '1;
            step(4);
            sh_g = 4'h1;
            step(5);
            check($sformatf("R5 settle%0d before", s), flt_gnd, 0);
            step(1);
            check($sformatf("R5 settle%0d at T+2", s), flt_gnd, 4'h1);
        end

        // R8 runs shorter than threshold never declare
        flush();
        cfg_thresh = 4'd3; drv_val = '1;
        step(4);
        for (int k = 0; k < 4; k++) begin
            sh_g = 4'h1; step(2);
            sh_g = 4'h0; step(1);
        end
        step(4);
        check("R8 intermittent", flt_gnd, 0);

        // R6 lagging pad
        for (int m = 0; m < 3; m++) begin
            flush();
            cfg_thresh = 4'd2; cfg_settle2 = (m != 0);
            lag_en = 4'h1;
            step(3);
            for (int k = 0; k < 12; k++) begin
                if (m == 2) begin
                    if (k % 2 == 0) drv_val[0] = ~drv_val[0];
                end else begin
                    drv_val[0] = ~drv_val[0];
                end
                step(1);
            end
            step(4);
            check($sformatf("R6 lag mode%0d", m), (flt_gnd | flt_vdd) & 4'h1, (m == 0) ? 1 : 0);
        end

        // R9 selective clear and hold, R10 mask
        flush();
        drv_val = '1; sh_g = 4'h3;
        step(6);
        sh_g = '0;
        step(4);
        check("R9 set", flt_gnd, 4'h3);
        clear(4'h1);
        check("R9 selective clear", flt_gnd, 4'h2);
        step(10);
        check("R9 hold", flt_gnd, 4'h2);
        irq_mask = 4'h2;
        step(1);
        check("R10 masked", fault_irq, 0);
        irq_mask = 4'h0;
        step(1);
        check("R10 unmasked", fault_irq, 1);

        // R11 disable then restore on clear
        flush();
        cfg_autodis = 1'b1; drv_val = '1; sh_g = 4'h1;
        step(6);
        check("R11 disabled", pad_oe, 4'hE);
        sh_g = '0;
        clear(4'h1);
        check("R11 restored", pad_oe, 4'hF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule